// File: doc/BRIEF.md
# Two-Wire Write-Only Nonvolatile Byte Slave

This block is a slave on a two-wire serial bus in front of a small nonvolatile byte array, 16 bytes deep by default. A master reaches it with one kind of transaction only, a single-byte random write. The master sends a start, the device byte with the direction bit, a register index and one data byte, then a stop. The block checks its own device code. It acknowledges each accepted byte by pulling the data line low. It hands the byte to the array through a one-cycle write port only once the stop has been seen.

The write port pulse starts a timed internal write interval, set by a parameter in system clocks. During that interval the block ignores the bus entirely and drives no acknowledge. Both bus lines arrive as asynchronous, oversampled inputs and are synchronised to the system clock. The data-line output is an open-drain pull-low request.

Top module: `eew_wr_slave`

## Requirements
- R1: After reset, sda_pull_o, wr_en_o and busy_o are all low.
- R2: A device byte whose upper nibble is binary 1010 and whose bit 0 (direction) is 0 is acknowledged, whatever bits 3..1 hold. Acknowledge means sda_pull_o is high while SCL is high during the ninth clock of that byte.
- R3: A device byte with a different upper nibble, or with the direction bit set to 1, is not acknowledged. Nothing later in that transfer is acknowledged, and no write follows.
- R4: Once the device byte is accepted, the register-index byte and the data byte are each acknowledged on their ninth clock.
- R5: Bytes are shifted in most-significant bit first. Only the low 4 bits of the register index select the array entry.
- R6: A stop that follows a complete data byte produces exactly one wr_en_o pulse of one clock, carrying the index and the data byte. There is no other write.
- R7: busy_o rises on the cycle after the wr_en_o pulse and stays high for exactly WRITE_CYCLES clocks.
- R8: While busy_o is high, sda_pull_o stays low, wr_en_o stays low, and a transfer started in that interval is ignored.
- R9: A start received before the data byte is complete aborts the transfer. A stop received before the data byte is complete also ends it. In both cases no write is made.
- R10: Bytes sent after the data byte are not acknowledged, and the following stop still commits the first data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | Open-drain request: 1 pulls the data line low |
| wr_en_o | output | 1 | One-cycle array write strobe |
| wr_addr_o | output | 4 | Array byte index |
| wr_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Internal write interval in progress |

## Verification
The bench goes after the device-code corners. A code that differs only in the three don't-care bits must still be acknowledged, and a read-direction code must be refused. A decoder that compared all seven bits, or ignored the direction bit, would accept or reject the wrong frames. A register index above 15 must land on its low nibble; a design that took the high bits or wrapped badly would write the wrong entry. The bench also issues a repeated start in mid-byte and a stop right after the index, and a design that committed early would write on either one. It sends an address during the busy window, which a design that only gated writes would still acknowledge. Finally it sends an extra byte after the data, which a design with page behaviour would acknowledge and then store over the first byte.

// File: rtl/eew_pkg.sv
package eew_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [3:0] DEV_TAG = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK,
    ST_HOLD,
    ST_SKIP
  } state_e;

  typedef enum logic [1:0] {
    FLD_DEV,
    FLD_REG,
    FLD_DATA
  } field_e;
endpackage

// File: rtl/eew_bus_sync.sv
module eew_bus_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  assign scl_s = scl_sr[SYNC_STAGES-1];
  assign sda_s = sda_sr[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // data edges while the clock stays high frame a transfer
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eew_frame.sv
module eew_frame
  import eew_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              busy_i,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  state_e             state_q;
  field_e             field_q;
  logic [CNT_W-1:0]   bit_cnt_q;
  logic [BYTE_W-1:0]  shreg_q;
  logic [ADDR_W-1:0]  reg_q;
  logic [BYTE_W-1:0]  data_q;
  logic               byte_done;
  logic               dev_match;

  assign byte_done = scl_fall_i && (bit_cnt_q == CNT_W'(BYTE_W));
  assign dev_match = (shreg_q[BYTE_W-1 -: 4] == DEV_TAG) && !shreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      field_q    <= FLD_DEV;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      reg_q      <= '0;
      data_q     <= '0;
      sda_pull_o <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (busy_i) begin
        state_q    <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (start_i) begin
        state_q    <= ST_SHIFT;
        field_q    <= FLD_DEV;
        bit_cnt_q  <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_i) begin
        if (state_q == ST_HOLD) begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= reg_q;
          wr_data_o <= data_q;
        end
        state_q    <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_SHIFT: begin
            if (scl_rise_i) begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (byte_done) begin
              unique case (field_q)
                FLD_DEV: begin
                  state_q    <= dev_match ? ST_ACK : ST_SKIP;
                  sda_pull_o <= dev_match;
                end
                FLD_REG: begin
                  reg_q      <= shreg_q[ADDR_W-1:0];
                  state_q    <= ST_ACK;
                  sda_pull_o <= 1'b1;
                end
                default: begin
                  data_q     <= shreg_q;
                  state_q    <= ST_ACK;
                  sda_pull_o <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              sda_pull_o <= 1'b0;
              bit_cnt_q  <= '0;
              unique case (field_q)
                FLD_DEV: begin field_q <= FLD_REG;  state_q <= ST_SHIFT; end
                FLD_REG: begin field_q <= FLD_DATA; state_q <= ST_SHIFT; end
                default: state_q <= ST_HOLD;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eew_busy_timer.sv
module eew_busy_timer #(
  parameter int unsigned WRITE_CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(WRITE_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(WRITE_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eew_wr_slave.sv
module eew_wr_slave #(
  parameter int unsigned DEPTH        = 16,
  parameter int unsigned WRITE_CYCLES = 500000,
  parameter int unsigned SYNC_STAGES  = 2,
  localparam int unsigned ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              busy_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  eew_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  eew_frame #(.ADDR_W(ADDR_W)) i_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .busy_i     (busy_o),
    .sda_pull_o (sda_pull_o),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  eew_busy_timer #(.WRITE_CYCLES(WRITE_CYCLES)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr_en_o),
    .busy_o (busy_o)
  );
endmodule

// File: rtl/eew_checker.sv
module eew_checker #(
  parameter int unsigned WRITE_CYCLES = 500000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sda_pull_o,
  input logic wr_en_o,
  input logic busy_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  a_r6_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  a_r7_busy_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> busy_o);

  a_r7_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == WRITE_CYCLES);

  a_r7_busy_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q < WRITE_CYCLES);

  a_r8_no_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_pull_o);

  a_r8_no_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !wr_en_o);
endmodule

bind eew_wr_slave eew_checker #(.WRITE_CYCLES(WRITE_CYCLES)) i_eew_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_pull_o (sda_pull_o),
  .wr_en_o    (wr_en_o),
  .busy_o     (busy_o)
);

// File: tb/test_eew_wr_slave.sv
module test_eew_wr_slave;
  localparam int WC = 300;
  localparam int Q  = 8;

  typedef struct packed {
    logic [7:0] dev;
    logic [7:0] idx;
    logic [7:0] data;
    logic       acked;
    logic [3:0] exp_addr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{dev: 8'hA0, idx: 8'h03, data: 8'h5A, acked: 1'b1, exp_addr: 4'h3},
    '{dev: 8'hAE, idx: 8'h1F, data: 8'hC3, acked: 1'b1, exp_addr: 4'hF},
    '{dev: 8'hA6, idx: 8'hE0, data: 8'h01, acked: 1'b1, exp_addr: 4'h0},
    '{dev: 8'hB0, idx: 8'h04, data: 8'h77, acked: 1'b0, exp_addr: 4'h0},
    '{dev: 8'hA1, idx: 8'h05, data: 8'h66, acked: 1'b0, exp_addr: 4'h0},
    '{dev: 8'h20, idx: 8'h06, data: 8'h55, acked: 1'b0, exp_addr: 4'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull, wr_en, busy;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic sda_line;

  int checks = 0, fails = 0, cycles = 0;
  int wr_cnt = 0, run = 0, last_run = 0;
  logic [3:0] last_addr = '0;
  logic [7:0] last_data = '0;
  logic pull_in_busy = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  eew_wr_slave #(.WRITE_CYCLES(WC)) i_eew_wr_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .busy_o(busy)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (wr_en) begin wr_cnt++; last_addr = wr_addr; last_data = wr_data; end
    if (busy) run++;
    else if (run != 0) begin last_run = run; run = 0; end
    if (busy && sda_pull) pull_in_busy = 1'b1;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d exp<150000", cycles);
      finish_run();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b1; w(Q);
  endtask

  task automatic send_bit(logic b);
    m_sda = b; w(Q); m_scl = 1'b1; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q/2);
    ack = sda_pull;
    w(Q/2); m_scl = 1'b0; w(Q);
  endtask

  task automatic wait_idle();
    w(8);
    while (busy) w(1);
    w(4);
  endtask

  initial begin
    logic a0, a1, a2, a3;
    int base;
    w(3);
    chk("R1 pull", sda_pull, 0);
    chk("R1 wr_en", wr_en, 0);
    chk("R1 busy", busy, 0);
    rst_n = 1'b1;
    w(4);

    // table of single-byte writes
    for (int v = 0; v < NV; v++) begin
      base = wr_cnt;
      bus_start();
      send_byte(VECS[v].dev, a0);
      send_byte(VECS[v].idx, a1);
      send_byte(VECS[v].data, a2);
      bus_stop();
      w(6);
      if (VECS[v].acked) begin
        chk("R2 dev ack", a0, 1);
        chk("R4 idx ack", a1, 1);
        chk("R4 data ack", a2, 1);
        chk("R6 one write", wr_cnt - base, 1);
        chk("R5 addr", last_addr, VECS[v].exp_addr);
        chk("R5 data", last_data, VECS[v].data);
        wait_idle();
        chk("R7 busy length", last_run, WC);
      end else begin
        chk("R3 dev nack", a0, 0);
        chk("R3 later nack", a1 | a2, 0);
        chk("R3 no write", wr_cnt - base, 0);
        wait_idle();
      end
    end

    // R8: transfer issued while busy
    bus_start();
    send_byte(8'hA0, a0); send_byte(8'h02, a1); send_byte(8'h11, a2);
    bus_stop();
    w(3);
    chk("R8 busy high after stop", busy, 1);
    base = wr_cnt;
    bus_start();
    send_byte(8'hA0, a0);
    chk("R8 no ack while busy", a0, 0);
    send_byte(8'h02, a1); send_byte(8'h99, a2);
    bus_stop();
    wait_idle();
    chk("R8 no write while busy", wr_cnt - base, 0);
    chk("R8 no pull while busy", pull_in_busy, 0);

    // R9: repeated start in the middle of the data byte
    base = wr_cnt;
    bus_start();
    send_byte(8'hA0, a0); send_byte(8'h07, a1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_start();
    bus_stop();
    w(6);
    chk("R9 restart aborts", wr_cnt - base, 0);

    // R9: stop right after the index byte
    bus_start();
    send_byte(8'hA0, a0); send_byte(8'h08, a1);
    bus_stop();
    w(6);
    chk("R9 early stop", wr_cnt - base, 0);
    chk("R9 busy stays low", busy, 0);

    // R10: extra byte after the data byte
    base = wr_cnt;
    bus_start();
    send_byte(8'hA2, a0); send_byte(8'h09, a1); send_byte(8'h3C, a2); send_byte(8'hF0, a3);
    bus_stop();
    w(6);
    chk("R10 extra byte nack", a3, 0);
    chk("R10 one write", wr_cnt - base, 1);
    chk("R10 first data kept", last_data, 8'h3C);
    chk("R10 addr", last_addr, 4'h9);
    wait_idle();

    finish_run();
  end
endmodule